// File: doc/BRIEF.md
# Control-Bit Configurable ALU

A purely combinational 16-bit arithmetic logic unit for a simple datapath. It has no opcode decoder. Six independent control bits shape the result, and they act in a fixed order.

- Each of the two operands can first be forced to zero and then bitwise inverted.
- A selector then picks either the modular sum or the bitwise AND of the two conditioned operands.
- A final control can invert that intermediate value.

Taken together, these six bits reach eighteen useful functions: constants, pass-through, complement, negation, increment, decrement, add, both subtraction orders, AND and OR.

Two flags come with every result. One reports a result of exactly zero. The other reports a negative result in two's complement, which is the most significant bit. A sequencer reads these flags to make branch decisions. The operand and result width is a parameter, with a default of 16.

Top module: `cond_alu`

## Requirements
- R1: When `clr_a` is 1, operand A is replaced by zero before `flip_a` is applied. With `clr_a`=1 and `flip_a`=1, A therefore becomes all ones, regardless of `opa`.
- R2: When `flip_a` is 1, the (possibly cleared) operand A is bitwise inverted.
- R3: `clr_b` and `flip_b` condition operand B in the same order and manner as R1/R2 condition A.
- R4: When `sum_sel` is 1, the intermediate value is the sum of the conditioned operands modulo 2^16, and the carry out is discarded.
- R5: When `sum_sel` is 0, the intermediate value is the bitwise AND of the conditioned operands.
- R6: When `flip_out` is 1, `result` is the bitwise inverse of the intermediate value; otherwise it equals the intermediate value.
- R7: `is_zero` is 1 exactly when `result` is 0.
- R8: `is_neg` equals bit 15 of `result`.
- R9: The control code {clr_a,flip_a,clr_b,flip_b,sum_sel,flip_out} = 010011 yields opa−opb, and the code 000111 yields opb−opa, both modulo 2^16.
- R10: The codes 101010, 111111 and 111010 (same bit order as R9) yield the constants 0, 1 and −1 (0xFFFF), independent of `opa` and `opb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 16 | Operand A |
| opb | input | 16 | Operand B |
| clr_a | input | 1 | Force A to zero |
| flip_a | input | 1 | Invert A after clearing |
| clr_b | input | 1 | Force B to zero |
| flip_b | input | 1 | Invert B after clearing |
| sum_sel | input | 1 | 1: add, 0: AND |
| flip_out | input | 1 | Invert the intermediate value |
| result | output | 16 | ALU output |
| is_zero | output | 1 | Result equals zero |
| is_neg | output | 1 | Result MSB |

## Verification
The block holds no state, so any fault in a conditioning stage or in the combiner shows up on `result` and the flags as soon as the inputs settle. The weak points are the order of clear and invert, and carry handling at the top bit. The bench therefore drives all eighteen control codes over operand pairs that include zero, all ones, and the signed boundaries. A swapped clear/invert order or a dropped carry shows up as a wrong value on `result`, and also as a wrong `is_zero` or `is_neg`, for the same input vector.

// File: rtl/cond_alu_pkg.sv
package cond_alu_pkg;
  typedef struct packed {
    logic clr;
    logic flip;
  } prep_ctl_t;

  typedef struct packed {
    logic sum_sel;
    logic flip_out;
  } post_ctl_t;
endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep
  import cond_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] raw,
  input  prep_ctl_t    ctl,
  output logic [W-1:0] cond
);
  logic [W-1:0] cleared;

  always_comb begin
    cleared = ctl.clr ? '0 : raw;
    cond    = ctl.flip ? ~cleared : cleared;
  end

  always_comb begin
    if (ctl.clr && ctl.flip)
      AST_CLR_THEN_FLIP: assert (&cond) else $error("clear must precede invert"); // R1
    if (ctl.clr && !ctl.flip)
      AST_CLR_ONLY: assert (cond == '0) else $error("clear failed"); // R3
  end
endmodule

// File: rtl/alu_combine.sv
module alu_combine
  import cond_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  post_ctl_t    ctl,
  output logic [W-1:0] mid
);
  logic [W-1:0] sum_v;
  logic [W-1:0] and_v;

  always_comb begin
    sum_v = a + b;
    and_v = a & b;
    mid   = ctl.sum_sel ? sum_v : and_v;
  end
endmodule

// File: rtl/alu_finish.sv
module alu_finish
  import cond_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] mid,
  input  post_ctl_t    ctl,
  output logic [W-1:0] res,
  output logic         zr,
  output logic         ng
);
  always_comb begin
    res = ctl.flip_out ? ~mid : mid;
    zr  = ~|res;
    ng  = res[W-1];
  end

  always_comb begin
    if (zr)
      AST_ZERO_NOT_NEG: assert (!ng) else $error("zero and negative both set"); // R7
    if (ctl.flip_out && &mid)
      AST_INV_ONES: assert (zr) else $error("inverted ones not zero"); // R6
  end
endmodule

// File: rtl/cond_alu.sv
module cond_alu
  import cond_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         clr_a,
  input  logic         flip_a,
  input  logic         clr_b,
  input  logic         flip_b,
  input  logic         sum_sel,
  input  logic         flip_out,
  output logic [W-1:0] result,
  output logic         is_zero,
  output logic         is_neg
);
  localparam int NOPS = 2;

  logic [W-1:0] raw_ops  [NOPS];
  logic [W-1:0] cond_ops [NOPS];
  prep_ctl_t    prep_ctl [NOPS];
  post_ctl_t    post_ctl;
  logic [W-1:0] mid;

  always_comb begin
    raw_ops[0]  = opa;
    raw_ops[1]  = opb;
    prep_ctl[0] = '{clr: clr_a, flip: flip_a};
    prep_ctl[1] = '{clr: clr_b, flip: flip_b};
    post_ctl    = '{sum_sel: sum_sel, flip_out: flip_out};
  end

  for (genvar g = 0; g < NOPS; g++) begin : g_prep
    alu_operand_prep #(.W(W)) u_prep (
      .raw  (raw_ops[g]),
      .ctl  (prep_ctl[g]),
      .cond (cond_ops[g])
    );
  end

  alu_combine #(.W(W)) u_comb (
    .a   (cond_ops[0]),
    .b   (cond_ops[1]),
    .ctl (post_ctl),
    .mid (mid)
  );

  alu_finish #(.W(W)) u_fin (
    .mid (mid),
    .ctl (post_ctl),
    .res (result),
    .zr  (is_zero),
    .ng  (is_neg)
  );

  logic [5:0] code;
  logic [W-1:0] diff_ab;
  logic [W-1:0] diff_ba;
  logic [W-1:0] add_ab;
  always_comb begin
    code    = {clr_a, flip_a, clr_b, flip_b, sum_sel, flip_out};
    diff_ab = opa - opb;
    diff_ba = opb - opa;
    add_ab  = opa + opb;
    if (code == 6'b010011)
      AST_SUB_AB: assert (result == diff_ab) else $error("a-b wrong"); // R9
    if (code == 6'b000111)
      AST_SUB_BA: assert (result == diff_ba) else $error("b-a wrong"); // R9
    if (code == 6'b000010)
      AST_ADD_AB: assert (result == add_ab) else $error("a+b wrong"); // R4
    if (code == 6'b111010)
      AST_CONST_M1: assert (&result) else $error("-1 wrong"); // R10
  end
endmodule

// File: tb/cond_alu_test.sv
module cond_alu_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [15:0] opa, opb, result;
  logic clr_a, flip_a, clr_b, flip_b, sum_sel, flip_out;
  logic is_zero, is_neg;

  int checks = 0;
  int failures = 0;

  cond_alu #(.W(16)) uut (
    .opa(opa), .opb(opb),
    .clr_a(clr_a), .flip_a(flip_a), .clr_b(clr_b), .flip_b(flip_b),
    .sum_sel(sum_sel), .flip_out(flip_out),
    .result(result), .is_zero(is_zero), .is_neg(is_neg)
  );

  localparam int NFUNC = 18;
  localparam logic [5:0] CODES [NFUNC] = '{
    6'b101010, 6'b111111, 6'b111010, 6'b001100, 6'b110000, 6'b001101,
    6'b110001, 6'b001111, 6'b110011, 6'b011111, 6'b110111, 6'b001110,
    6'b110010, 6'b000010, 6'b010011, 6'b000111, 6'b000000, 6'b010101};
  localparam int NPAIR = 6;
  localparam logic [31:0] PAIRS [NPAIR] = '{
    {16'h0000, 16'h0000}, {16'h0005, 16'h0003}, {16'h0003, 16'h0005},
    {16'hFFFF, 16'h0001}, {16'h8000, 16'h7FFF}, {16'h1234, 16'hABCD}};

  function automatic logic [15:0] model(int id, logic [15:0] x, logic [15:0] y);
    case (id)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'hFFFF;
      3: return x;
      4: return y;
      5: return ~x;
      6: return ~y;
      7: return 16'(0 - x);
      8: return 16'(0 - y);
      9: return 16'(x + 1);
      10: return 16'(y + 1);
      11: return 16'(x - 1);
      12: return 16'(y - 1);
      13: return 16'(x + y);
      14: return 16'(x - y);
      15: return 16'(y - x);
      16: return x & y;
      default: return x | y;
    endcase
  endfunction

  function automatic string tag(int id);
    case (id)
      0, 1, 2: return "R10";
      3, 5, 7, 9, 11: return "R2";
      4, 6, 8, 10, 12: return "R3";
      13: return "R4";
      14, 15: return "R9";
      16: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [5:0] c, logic [15:0] x, logic [15:0] y);
    @(posedge clk);
    {clr_a, flip_a, clr_b, flip_b, sum_sel, flip_out} = c;
    opa = x;
    opb = y;
    @(negedge clk);
  endtask

  task automatic flags(logic [15:0] exp);
    check("R7", {15'd0, is_zero}, {15'd0, exp == 16'h0});
    check("R8", {15'd0, is_neg}, {15'd0, exp[15]});
  endtask

  initial begin
    // reset-like idle state: all controls low, operands zero -> AND gives 0
    apply(6'b000000, 16'h0, 16'h0);
    check("R5", result, 16'h0);
    flags(16'h0);

    for (int p = 0; p < NPAIR; p++) begin
      for (int f = 0; f < NFUNC; f++) begin
        logic [15:0] x, y, e;
        x = PAIRS[p][31:16];
        y = PAIRS[p][15:0];
        e = model(f, x, y);
        apply(CODES[f], x, y);
        check(tag(f), result, e);
        flags(e);
      end
    end

    // R1: clear then invert A gives all ones; AND with B returns B
    apply(6'b110000, 16'h5A5A, 16'h3C3C);
    check("R1", result, 16'h3C3C);
    // R3: clear then invert B; AND returns A
    apply(6'b001100, 16'hC3C3, 16'h1111);
    check("R3", result, 16'hC3C3);
    // R4: carry out discarded
    apply(6'b000010, 16'hFFFF, 16'h0001);
    check("R4", result, 16'h0000);
    flags(16'h0000);
    apply(6'b000010, 16'h7FFF, 16'h0001);
    check("R4", result, 16'h8000);
    flags(16'h8000);
    // R6: inverted AND
    apply(6'b000001, 16'hF0F0, 16'hFF00);
    check("R6", result, 16'h0FFF);
    // R10: constants ignore operands
    apply(6'b101010, 16'hDEAD, 16'hBEEF);
    check("R10", result, 16'h0000);
    apply(6'b111111, 16'hDEAD, 16'hBEEF);
    check("R10", result, 16'h0001);
    // R9: subtraction wrap
    apply(6'b010011, 16'h0000, 16'h0001);
    check("R9", result, 16'hFFFF);
    flags(16'hFFFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule